// File: doc/BRIEF.md
# Banked Register Address Mapper

This block sits behind a serial register link and turns each 7-bit register address into a storage location. The upper half of the address space (MSB set) reaches a small file of fixed slave registers held inside the block. The lower half is a 64-byte window onto an external byte memory. Which of up to 16 banks the window shows is chosen by a bank-select input; the physical byte address is the bank number times 64 plus the six low address bits.

A write to address 0 while bank 0 is selected is a soft-reset command. The byte is still stored at physical address 0, and a one-clock reset pulse follows. That pulse clears the period counter and the sticky configuration-error flags. It also loads the write-protect and timeout settings from slave register 0, which makes them take effect, and tells the output stages that they are released. Reads return data in the same cycle and only while the slave-to-master direction is enabled.

Requests use a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only in the single cycle in which the reset pulse is high, and a request offered in that cycle is neither stored nor read. The master keeps the request asserted until the handshake completes. Read data and `rd_ok` are valid in the accepting cycle only.

Top module: `bam_mapper`

## Requirements
- R1: Addresses 0x40..0x7F select the slave register file. Index = address bits [5:0]. Indices 0..7 are stored and read back. Higher indices ignore writes and read as 0. `region` is 1 for these addresses.
- R2: Addresses 0x00..0x3F give `region` = 0 and `mem_addr` = bank*64 + address[5:0]. An accepted write drives `mem_we` = 1 with `mem_wdata` = `req_wdata`. A slave-region write never drives `mem_we`.
- R3: The bank number is `bank_sel` modulo 16, i.e. only `bank_sel[3:0]` matters.
- R4: An accepted write to address 0x00 with bank 0 is stored at physical address 0 and raises `soft_rst` in the next cycle, for exactly one cycle. The same write with any other bank raises no pulse.
- R5: `req_ready` is low in the cycle where `soft_rst` is high. A request offered then causes no memory write.
- R6: At the end of the `soft_rst` cycle, `pcnt` becomes 0 and `cfg_err` becomes 0.
- R7: `wp_active` and `tmo_sel` take slave register 0 bit 0 and bits [7:4] at the end of the `soft_rst` cycle. Writing that register changes neither output until a soft reset.
- R8: While `wp_active` = 1, writes to the banked region do not drive `mem_we`, except the soft-reset write of R4. Slave-region writes are still stored.
- R9: While `rd_enable` = 0, reads return `rd_data` = 0 and `rd_ok` = 0. Writes are still accepted.
- R10: An accepted read with `rd_enable` = 1 gives `rd_ok` = 1 in the same cycle. `rd_data` is `mem_rdata` for the banked region or the slave register value for the slave region.
- R11: After `rst_n` low: `soft_rst` = 0, `req_ready` = 1, `pcnt` = 0, `cfg_err` = 0, `wp_active` = 0, `tmo_sel` = 0, and all slave registers read 0.
- R12: `pcnt` increments on each cycle with `pcnt_inc` high. `cfg_err` bits are set by `err_set` and stay set until a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Link register address |
| req_wdata | input | 8 | Write byte |
| bank_sel | input | 8 | Bank select value (modulo 16) |
| rd_enable | input | 1 | Slave-to-master direction enabled |
| rd_data | output | 8 | Read byte, valid in the accepting cycle |
| rd_ok | output | 1 | Read accepted and returned |
| region | output | 1 | 0 = banked memory, 1 = slave registers |
| mem_addr | output | 10 | Physical memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte at `mem_addr` |
| soft_rst | output | 1 | One-cycle internal reset pulse |
| pcnt_inc | input | 1 | Period counter increment |
| pcnt | output | 24 | Period counter |
| err_set | input | 4 | Configuration-error set bits |
| cfg_err | output | 4 | Sticky configuration-error flags |
| wp_active | output | 1 | Applied write protect |
| tmo_sel | output | 4 | Applied timeout setting |

## Verification
The assertions check every cycle that the reset pulse is one cycle wide and is preceded by an accepted write to address 0 in bank 0. They also check that no memory write happens in the pulse cycle or from the slave region, that only the soft-reset write gets through write protect, that reads are gated, and that the counter and flags are zero after a pulse. The bench scenarios show the things no single-cycle property can see:
- the exact physical address for each bank and address pair, including bank values above 15;
- that data written earlier is read back from the right region;
- that write-protect and timeout settings stay unchanged until a soft reset loads them;
- that a write dropped under protect or back-pressure is missing when it is read later.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic {
    REG_BANKED = 1'b0,
    REG_SLAVE  = 1'b1
  } region_e;
endpackage

// File: rtl/bam_decode.sv
module bam_decode #(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 4,
  parameter int SLV_N  = 8,
  localparam int WIN_W  = ADDR_W - 1,
  localparam int PHYS_W = BANK_W + WIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 is_write,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 wp_active,
  output bam_pkg::region_e     region,
  output logic [PHYS_W-1:0]    phys_addr,
  output logic [WIN_W-1:0]     slv_idx,
  output logic                 slv_hit,
  output logic                 mem_we,
  output logic                 slv_we,
  output logic                 trigger
);
  import bam_pkg::*;

  logic wr_fire;
  logic at_zero;

  always_comb begin
    region    = addr[ADDR_W-1] ? REG_SLAVE : REG_BANKED;
    slv_idx   = addr[WIN_W-1:0];
    phys_addr = {bank, addr[WIN_W-1:0]};
    slv_hit   = (int'(slv_idx) < SLV_N);
    wr_fire   = fire && is_write;
    at_zero   = (addr == '0) && (bank == '0);
    trigger   = wr_fire && at_zero;
    mem_we    = wr_fire && (region == REG_BANKED) && (!wp_active || at_zero);
    slv_we    = wr_fire && (region == REG_SLAVE) && slv_hit;
  end

  assert_bank_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !addr[ADDR_W-1]);

  assert_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_active && mem_we) |-> trigger);

  assert_slave_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slv_we |-> (addr[ADDR_W-1] && is_write && fire));
endmodule

// File: rtl/bam_slave_regs.sv
module bam_slave_regs #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6,
  parameter int SLV_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] reg0
);
  logic [DATA_W-1:0] regs [SLV_N];

  for (genvar g = 0; g < SLV_N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (int'(idx) == g)) begin
        regs[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < SLV_N; k++) begin
      if (hit && (int'(idx) == k)) rdata = regs[k];
    end
    reg0 = regs[0];
  end

  assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> (regs[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/bam_reset_ctl.sv
module bam_reset_ctl #(
  parameter int PCNT_W = 24,
  parameter int ERR_W  = 4,
  parameter int TMO_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic              pcnt_inc,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              cfg_wp,
  input  logic [TMO_W-1:0]  cfg_tmo,
  output logic              soft_rst,
  output logic [PCNT_W-1:0] pcnt,
  output logic [ERR_W-1:0]  cfg_err,
  output logic              wp_active,
  output logic [TMO_W-1:0]  tmo_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst  <= 1'b0;
      pcnt      <= '0;
      cfg_err   <= '0;
      wp_active <= 1'b0;
      tmo_sel   <= '0;
    end else begin
      soft_rst <= trigger;
      if (soft_rst) begin
        pcnt      <= '0;
        cfg_err   <= '0;
        wp_active <= cfg_wp;
        tmo_sel   <= cfg_tmo;
      end else begin
        if (pcnt_inc) pcnt <= pcnt + 1'b1;
        cfg_err <= cfg_err | err_set;
      end
    end
  end

  assert_pulse_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((pcnt == '0) && (cfg_err == '0)));

  assert_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ($stable(wp_active) && $stable(tmo_sel)));

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((cfg_err & $past(cfg_err)) == $past(cfg_err)));
endmodule

// File: rtl/bam_mapper.sv
module bam_mapper #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int SEL_W  = 8,
  parameter int SLV_N  = 8,
  parameter int PCNT_W = 24,
  parameter int ERR_W  = 4,
  parameter int TMO_W  = 4,
  localparam int WIN_W  = ADDR_W - 1,
  localparam int PHYS_W = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic              rd_enable,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ok,
  output logic              region,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              soft_rst,
  input  logic              pcnt_inc,
  output logic [PCNT_W-1:0] pcnt,
  input  logic [ERR_W-1:0]  err_set,
  output logic [ERR_W-1:0]  cfg_err,
  output logic              wp_active,
  output logic [TMO_W-1:0]  tmo_sel
);
  import bam_pkg::*;

  logic [BANK_W-1:0] bank;
  logic              fire;
  region_e           reg_sel;
  logic [WIN_W-1:0]  slv_idx;
  logic              slv_hit;
  logic              slv_we;
  logic              trigger;
  logic [DATA_W-1:0] slv_rdata;
  logic [DATA_W-1:0] slv_reg0;
  logic              unused_bank_hi;
  logic              unused_cfg_mid;

  assign bank           = bank_sel[BANK_W-1:0];
  assign unused_bank_hi = ^bank_sel[SEL_W-1:BANK_W];
  assign unused_cfg_mid = ^slv_reg0[DATA_W-TMO_W-1:1];
  assign req_ready      = !soft_rst;
  assign fire           = req_valid && req_ready;
  assign mem_wdata      = req_wdata;
  assign region         = reg_sel;

  bam_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SLV_N(SLV_N)) u_decode (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(req_write),
    .addr(req_addr), .bank(bank), .wp_active(wp_active),
    .region(reg_sel), .phys_addr(mem_addr), .slv_idx(slv_idx),
    .slv_hit(slv_hit), .mem_we(mem_we), .slv_we(slv_we), .trigger(trigger)
  );

  bam_slave_regs #(.DATA_W(DATA_W), .IDX_W(WIN_W), .SLV_N(SLV_N)) u_slave (
    .clk(clk), .rst_n(rst_n), .we(slv_we), .idx(slv_idx), .hit(slv_hit),
    .wdata(req_wdata), .rdata(slv_rdata), .reg0(slv_reg0)
  );

  bam_reset_ctl #(.PCNT_W(PCNT_W), .ERR_W(ERR_W), .TMO_W(TMO_W)) u_rstctl (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .pcnt_inc(pcnt_inc),
    .err_set(err_set), .cfg_wp(slv_reg0[0]),
    .cfg_tmo(slv_reg0[DATA_W-1 -: TMO_W]),
    .soft_rst(soft_rst), .pcnt(pcnt), .cfg_err(cfg_err),
    .wp_active(wp_active), .tmo_sel(tmo_sel)
  );

  always_comb begin
    rd_ok   = fire && !req_write && rd_enable;
    rd_data = '0;
    if (rd_ok) rd_data = (reg_sel == REG_SLAVE) ? slv_rdata : mem_rdata;
  end

  assert_trigger_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(req_valid && req_write && (req_addr == '0) && (bank == '0)));

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!mem_we && !rd_ok));

  assert_read_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_enable |-> (!rd_ok && (rd_data == '0)));
endmodule

// File: tb/test_bam_mapper.sv
module test_bam_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] bank_sel = '0;
  logic       rd_enable = 1'b1;
  logic [7:0] rd_data;
  logic       rd_ok;
  logic       region;
  logic [9:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       soft_rst;
  logic       pcnt_inc = 1'b0;
  logic [23:0] pcnt;
  logic [3:0] err_set = '0;
  logic [3:0] cfg_err;
  logic       wp_active;
  logic [3:0] tmo_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mem [1024];

  always #2 clk = ~clk;

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  bam_mapper i_bam_mapper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_sel(bank_sel), .rd_enable(rd_enable), .rd_data(rd_data),
    .rd_ok(rd_ok), .region(region), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .soft_rst(soft_rst),
    .pcnt_inc(pcnt_inc), .pcnt(pcnt), .err_set(err_set), .cfg_err(cfg_err),
    .wp_active(wp_active), .tmo_sel(tmo_sel)
  );

  // {addr, bank_sel, expected physical address, expected region, expect mem_we}
  localparam logic [26:0] VEC [9] = '{
    {7'h05, 8'h00, 10'h005, 1'b0, 1'b1},
    {7'h3F, 8'h00, 10'h03F, 1'b0, 1'b1},
    {7'h00, 8'h01, 10'h040, 1'b0, 1'b1},
    {7'h21, 8'h03, 10'h0E1, 1'b0, 1'b1},
    {7'h3F, 8'h0F, 10'h3FF, 1'b0, 1'b1},
    {7'h10, 8'h12, 10'h090, 1'b0, 1'b1},
    {7'h00, 8'hF5, 10'h140, 1'b0, 1'b1},
    {7'h47, 8'h00, 10'h000, 1'b1, 1'b0},
    {7'h7F, 8'h06, 10'h000, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic w, input logic [6:0] a,
                       input logic [7:0] b, input logic [7:0] d);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; bank_sel = b; req_wdata = d;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 soft_rst", soft_rst, 0);
    check("R11 req_ready", req_ready, 1);
    check("R11 pcnt", pcnt, 0);
    check("R11 cfg_err", cfg_err, 0);
    check("R11 wp_active", wp_active, 0);
    check("R11 tmo_sel", tmo_sel, 0);
    apply(1, 0, 7'h42, 8'h00, 8'h00);
    check("R11 slave reg reads 0", rd_data, 0);

    // Vector walk: R2 R3 R1 decode and write strobes
    for (int i = 0; i < 9; i++) begin
      apply(1, 1, VEC[i][26:20], VEC[i][19:12], 8'h30 + 8'(i));
      check("R1 R2 region", region, VEC[i][1]);
      check("R2 mem_we", mem_we, VEC[i][0]);
      if (!VEC[i][1]) begin
        check("R2 R3 mem_addr", mem_addr, VEC[i][11:2]);
        check("R2 mem_wdata", mem_wdata, 8'h30 + 8'(i));
      end
    end

    // R1 slave store and out-of-range index
    apply(1, 1, 7'h43, 8'h00, 8'hA5);
    apply(1, 0, 7'h43, 8'h00, 8'h00);
    check("R1 R10 slave readback", rd_data, 8'hA5);
    check("R10 rd_ok", rd_ok, 1);
    apply(1, 0, 7'h47, 8'h00, 8'h00);
    check("R1 slave 0x47 from vector", rd_data, 8'h37);
    apply(1, 0, 7'h7F, 8'h00, 8'h00);
    check("R1 unimplemented index reads 0", rd_data, 8'h00);

    // R10 R3 banked reads
    apply(1, 0, 7'h21, 8'h13, 8'h00);
    check("R3 R10 bank 0x13 alias", rd_data, 8'h33);
    apply(1, 0, 7'h3F, 8'h00, 8'h00);
    check("R10 banked read", rd_data, 8'h31);

    // R9 read gating
    rd_enable = 1'b0;
    apply(1, 0, 7'h43, 8'h00, 8'h00);
    check("R9 blocked rd_data", rd_data, 0);
    check("R9 blocked rd_ok", rd_ok, 0);
    apply(1, 1, 7'h44, 8'h00, 8'h5A);
    apply(0, 0, 7'h00, 8'h00, 8'h00);
    rd_enable = 1'b1;
    apply(1, 0, 7'h44, 8'h00, 8'h00);
    check("R9 write taken while reads off", rd_data, 8'h5A);
    apply(0, 0, 7'h00, 8'h00, 8'h00);

    // R12 counter and sticky flags
    @(negedge clk) pcnt_inc = 1'b1;
    repeat (5) @(negedge clk);
    pcnt_inc = 1'b0;
    #1 check("R12 pcnt count", pcnt, 5);
    @(negedge clk) err_set = 4'h5;
    @(negedge clk) err_set = 4'h0;
    #1 check("R12 err set", cfg_err, 4'h5);
    @(negedge clk) err_set = 4'h8;
    @(negedge clk) err_set = 4'h0;
    #1 check("R12 err sticky", cfg_err, 4'hD);

    // R7 config write does not apply yet
    apply(1, 1, 7'h40, 8'h00, 8'h91);
    apply(0, 0, 7'h00, 8'h00, 8'h00);
    check("R7 wp unchanged", wp_active, 0);
    check("R7 tmo unchanged", tmo_sel, 0);

    // R4 address 0 in another bank: no pulse
    apply(1, 1, 7'h00, 8'h02, 8'h11);
    apply(0, 0, 7'h00, 8'h00, 8'h00);
    check("R4 no pulse for bank 2", soft_rst, 0);

    // R4 trigger
    apply(1, 1, 7'h00, 8'h00, 8'h77);
    check("R4 trigger write committed", mem_we, 1);
    apply(1, 1, 7'h10, 8'h01, 8'hEE);
    check("R4 pulse high", soft_rst, 1);
    check("R5 ready low", req_ready, 0);
    check("R5 no write during pulse", mem_we, 0);
    apply(0, 0, 7'h00, 8'h00, 8'h00);
    check("R4 pulse one cycle", soft_rst, 0);
    check("R6 pcnt cleared", pcnt, 0);
    check("R6 err cleared", cfg_err, 0);
    check("R7 wp applied", wp_active, 1);
    check("R7 tmo applied", tmo_sel, 4'h9);
    apply(1, 0, 7'h10, 8'h01, 8'h00);
    check("R5 dropped write absent", rd_data, 8'h00);

    // R8 write protect
    apply(1, 1, 7'h05, 8'h01, 8'hC3);
    check("R8 banked write blocked", mem_we, 0);
    apply(1, 1, 7'h45, 8'h00, 8'h3C);
    apply(1, 0, 7'h45, 8'h00, 8'h00);
    check("R8 slave write under protect", rd_data, 8'h3C);
    apply(1, 0, 7'h05, 8'h01, 8'h00);
    check("R8 protected location unchanged", rd_data, 8'h00);
    apply(1, 0, 7'h00, 8'h00, 8'h00);
    check("R4 stored at physical 0", rd_data, 8'h77);
    check("R4 read of 0 no pulse", mem_we, 0);
    apply(1, 1, 7'h00, 8'h00, 8'h88);
    check("R8 trigger passes protect", mem_we, 1);
    apply(0, 0, 7'h00, 8'h00, 8'h00);
    check("R4 pulse under protect", soft_rst, 1);
    apply(1, 0, 7'h00, 8'h00, 8'h00);
    check("R4 second trigger stored", rd_data, 8'h88);
    apply(0, 0, 7'h00, 8'h00, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule